// File: doc/BRIEF.md
# Serial-Loaded Converter Code Register

This block is the digital front end of a 12-bit voltage-output converter. A host sends 16-bit words over a three-wire link: an active-low frame select (`frame_n`), a bit clock (`bit_clk`) and a data line (`bit_dat`). While the frame is active, the block takes one bit, most significant first, on each falling edge of the bit clock. The three link inputs and the load strobe are asynchronous to the block clock. They pass through synchronizer stages, and edges are found by comparing each sampled value with the one before it.

Only the last 12 bits of each 16-bit word are kept. An active-low transfer strobe (`xfer_n`) copies them into a holding latch. That latch drives the converter code bus `dac_code`, which is in twos complement: 0x800 gives the most negative output, 0x7FF the most positive, and 0x000 bipolar zero.

The strobe has two uses. Pulsed low after a complete frame, it loads the latch once. Held low for good, it makes the latch update by itself as each sixteenth bit arrives. The host must keep a strobe pulse outside the active frame. Setup and hold times on the link are not checked.

Top module: `dac_serial_front`

## Requirements
- R1: A synchronous active-high `rst` clears `dac_code` to 0x000 (bipolar zero) on the next clock edge, and also clears the bit count and the pending-word flag.
- R2: A bit is taken only on a falling edge of `bit_clk` while `frame_n` is low, with the first bit of the word as its most significant bit. Edges of `bit_clk` while `frame_n` is high take no bit, and the bit count returns to zero whenever `frame_n` is high.
- R3: Of a 16-bit word, bits 11..0 (the last twelve received) become `dac_code[11:0]`. Bits 15..12 (the first four received) have no effect on `dac_code`.
- R4: With `xfer_n` high during a frame, driving `xfer_n` low after a complete 16-bit frame has ended loads the word's low 12 bits into `dac_code`.
- R5: With `xfer_n` held low, `dac_code` takes the new word's low 12 bits once the sixteenth bit has been received, with no further action.
- R6: A frame that ends with fewer than 16 bits never changes `dac_code`, and a later `xfer_n` pulse leaves `dac_code` unchanged.
- R7: Once 16 bits have been taken in a frame, any further falling edges in that frame are ignored, and the word is made of the first 16 bits.
- R8: While `xfer_n` is high, `dac_code` holds its value, whatever the serial activity.
- R9: The pending-word flag is set at the sixteenth bit and cleared by a load or by the first bit of a new frame. An `xfer_n` pulse with no word pending, including a second pulse after a load, leaves `dac_code` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Frame select, active low, asynchronous |
| bit_clk | input | 1 | Serial bit clock, asynchronous; a bit is taken on its falling edge |
| bit_dat | input | 1 | Serial data, most significant bit first |
| xfer_n | input | 1 | Transfer strobe, active low; held low selects automatic load |
| dac_code | output | 12 | Latched twos-complement converter code, registered |

## Verification
On every cycle the assertions check that the bit count never passes sixteen, that the shift register is left alone after the sixteenth bit, that the code holds while the strobe is high or no word is pending, that the sixteenth bit raises the pending flag, and that reset clears the code. Only the bench scenarios can show the word alignment: most significant bit first, the first four bits dropped, a short frame discarded, extra bits ignored. They also show that one strobe pulse loads exactly once and that automatic load follows each frame. For this the bench compares `dac_code` after each frame and strobe with a value computed from the bits it sent.

// File: rtl/dac_serial_pkg.sv
package dac_serial_pkg;

  // Width of a counter that must reach the value n inclusive.
  function automatic int count_width(input int n);
    int w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction

  typedef enum logic [1:0] {
    LD_IDLE    = 2'd0,
    LD_PENDING = 2'd1
  } load_state_e;

endpackage

// File: rtl/dac_serial_sync.sv
module dac_serial_sync #(
  parameter int          WIDTH   = 4,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] IDLE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= IDLE;
    else     stage_q[0] <= d_async;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[i] <= IDLE;
      else     stage_q[i] <= stage_q[i-1];
    end
  end

  assign d_sync = stage_q[STAGES-1];

endmodule

// File: rtl/dac_serial_shifter.sv
module dac_serial_shifter
  import dac_serial_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int CODE_BITS  = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_act,
  input  logic                 sclk_s,
  input  logic                 sdat_s,
  output logic [CODE_BITS-1:0] word_lo,
  output logic                 frame_first,
  output logic                 frame_done
);

  localparam int CNT_W = count_width(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

  logic                 sclk_prev;
  logic                 fall;
  logic                 take;
  logic [CNT_W-1:0]     cnt_q;
  logic [CODE_BITS-1:0] sr_q;

  // Falling-edge detect on the synchronized bit clock (idles high).
  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b1;
    else     sclk_prev <= sclk_s;
  end

  assign fall = sclk_prev & ~sclk_s;
  assign take = fall & frame_act & (cnt_q != FULL);

  // Bit counter: cleared whenever no frame is active.
  always_ff @(posedge clk) begin
    if (rst || !frame_act) cnt_q <= '0;
    else if (take)         cnt_q <= cnt_q + 1'b1;
  end

  // Only the last CODE_BITS bits are ever needed, so only they are kept.
  always_ff @(posedge clk) begin
    if (rst)       sr_q <= '0;
    else if (take) sr_q <= {sr_q[CODE_BITS-2:0], sdat_s};
  end

  assign word_lo     = sr_q;
  assign frame_first = take & (cnt_q == '0);
  assign frame_done  = take & (cnt_q == LAST);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL); // R7

  AST_FULL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == FULL) |=> $stable(sr_q)); // R7

  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    !frame_act |=> $stable(sr_q)); // R2

endmodule

// File: rtl/dac_serial_latch.sv
module dac_serial_latch
  import dac_serial_pkg::*;
#(
  parameter int CODE_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 xfer_act,
  input  logic                 frame_first,
  input  logic                 frame_done,
  input  logic [CODE_BITS-1:0] word_lo,
  output logic [CODE_BITS-1:0] code
);

  load_state_e st_q;
  logic        do_load;

  assign do_load = xfer_act & (st_q == LD_PENDING);

  always_ff @(posedge clk) begin
    if (rst)                 st_q <= LD_IDLE;
    else if (frame_done)     st_q <= LD_PENDING;
    else if (do_load || frame_first) st_q <= LD_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst)          code <= '0;
    else if (do_load) code <= word_lo;
  end

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (code == '0)); // R1

  AST_HOLD_STROBE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !xfer_act |=> $stable(code)); // R8

  AST_HOLD_NOT_PENDING: assert property (@(posedge clk) disable iff (rst)
    (st_q == LD_IDLE) |=> $stable(code)); // R9

  AST_DONE_PENDS: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> (st_q == LD_PENDING)); // R5

endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front #(
  parameter int FRAME_BITS  = 16,
  parameter int CODE_BITS   = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_n,
  input  logic                 bit_clk,
  input  logic                 bit_dat,
  input  logic                 xfer_n,
  output logic [CODE_BITS-1:0] dac_code
);

  // Idle levels: frame, clock and strobe high, data low.
  localparam logic [3:0] IDLE = 4'b1110;

  logic [3:0]           raw;
  logic [3:0]           syn;
  logic [CODE_BITS-1:0] word_lo;
  logic                 frame_first;
  logic                 frame_done;

  assign raw = {frame_n, bit_clk, xfer_n, bit_dat};

  dac_serial_sync #(
    .WIDTH (4),
    .STAGES(SYNC_STAGES),
    .IDLE  (IDLE)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(raw),
    .d_sync (syn)
  );

  dac_serial_shifter #(
    .FRAME_BITS(FRAME_BITS),
    .CODE_BITS (CODE_BITS)
  ) u_shift (
    .clk        (clk),
    .rst        (rst),
    .frame_act  (~syn[3]),
    .sclk_s     (syn[2]),
    .sdat_s     (syn[0]),
    .word_lo    (word_lo),
    .frame_first(frame_first),
    .frame_done (frame_done)
  );

  dac_serial_latch #(
    .CODE_BITS(CODE_BITS)
  ) u_latch (
    .clk        (clk),
    .rst        (rst),
    .xfer_act   (~syn[1]),
    .frame_first(frame_first),
    .frame_done (frame_done),
    .word_lo    (word_lo),
    .code       (dac_code)
  );

endmodule

// File: tb/tb_dac_serial_front.sv
`timescale 1ns/1ps
module tb_dac_serial_front;

  localparam int HALF = 3;     // block clocks per bit-clock phase
  localparam int SETTLE = 12;  // block clocks allowed for synchronizers and latch

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_n = 1'b1;
  logic        bit_clk = 1'b1;
  logic        bit_dat = 1'b0;
  logic        xfer_n = 1'b1;
  logic [11:0] dac_code;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [11:0] exp_code = 12'h000;

  always #10 clk = ~clk;

  dac_serial_front dut (
    .clk(clk), .rst(rst), .frame_n(frame_n), .bit_clk(bit_clk),
    .bit_dat(bit_dat), .xfer_n(xfer_n), .dac_code(dac_code)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run did not finish, got cycle %0d expected < 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [11:0] exp);
    n_cmp++;
    if (dac_code !== exp) begin
      n_bad++;
      $display("FAIL %s: dac_code got %03h expected %03h", req, dac_code, exp);
    end
  endtask

  // Word model: the first 16 bits sent form the word, code is its low 12 bits.
  function automatic logic [11:0] word_code(input logic [23:0] stream);
    return stream[19:8];
  endfunction

  // Send n bits of stream, MSB (bit 23) first.
  task automatic send_frame(input logic [23:0] stream, input int n);
    frame_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < n; i++) begin
      bit_dat = stream[23-i];
      tick(HALF);
      bit_clk = 1'b0;
      tick(HALF);
      bit_clk = 1'b1;
    end
    tick(HALF);
    frame_n = 1'b1;
    tick(HALF);
  endtask

  task automatic pulse_xfer();
    xfer_n = 1'b0;
    tick(HALF);
    xfer_n = 1'b1;
    tick(SETTLE);
  endtask

  initial begin
    tick(4);
    rst = 1'b0;
    tick(2);
    check("R1 reset state", 12'h000);

    // R4 / R3 / R8: manual load, upper four bits dropped, hold before strobe.
    send_frame({16'hA5C3, 8'h00}, 16);
    tick(SETTLE);
    check("R8 hold before strobe", exp_code);
    pulse_xfer();
    exp_code = word_code({16'hA5C3, 8'h00});
    check("R4 R3 manual load", exp_code);

    // R9: second strobe with nothing pending.
    pulse_xfer();
    check("R9 strobe without pending word", exp_code);

    // R6: short frame then strobe.
    send_frame({16'h1234, 8'h00}, 10);
    pulse_xfer();
    check("R6 short frame discarded", exp_code);

    // R7: over-length frame, first 16 bits kept.
    send_frame({16'h0F81, 8'h7E}, 20);
    pulse_xfer();
    exp_code = word_code({16'h0F81, 8'h7E});
    check("R7 extra bits ignored", exp_code);

    // R2: bit-clock edges with frame high take no bits; MSB-first alignment.
    for (int i = 0; i < 5; i++) begin
      bit_dat = 1'b1; tick(HALF); bit_clk = 1'b0; tick(HALF); bit_clk = 1'b1;
    end
    send_frame({16'h0800, 8'h00}, 16);
    pulse_xfer();
    exp_code = 12'h800;
    check("R2 msb first, idle edges ignored", exp_code);

    // R3: upper bits differ, low 12 equal -> same code.
    send_frame({16'hF800, 8'h00}, 16);
    pulse_xfer();
    check("R3 upper nibble has no effect", exp_code);

    // R9: pending word cancelled by start of a new, short frame.
    send_frame({16'h07FF, 8'h00}, 16);
    send_frame({16'h0123, 8'h00}, 5);
    pulse_xfer();
    check("R9 new frame clears pending", exp_code);

    // R5: automatic load with strobe held low.
    xfer_n = 1'b0;
    tick(SETTLE);
    send_frame({16'h07FF, 8'h00}, 16);
    tick(SETTLE);
    exp_code = 12'h7FF;
    check("R5 automatic load", exp_code);
    send_frame({16'h3ABC, 8'h00}, 16);
    tick(SETTLE);
    exp_code = 12'hABC;
    check("R5 automatic load second word", exp_code);
    send_frame({16'h5555, 8'h00}, 9);
    tick(SETTLE);
    check("R6 short frame in automatic mode", exp_code);
    xfer_n = 1'b1;
    tick(SETTLE);

    // Random mix of modes and lengths, fixed seed.
    void'($urandom(32'h5EED_0233));
    for (int k = 0; k < 60; k++) begin
      logic [23:0] s;
      int len;
      bit autom;
      s = 24'($urandom);
      len = 12 + int'($urandom % 9);
      autom = bit'($urandom % 2);
      if (autom) begin
        xfer_n = 1'b0;
        tick(SETTLE);
        send_frame(s, len);
        tick(SETTLE);
        if (len >= 16) exp_code = word_code(s);
        check(len >= 16 ? "R5 random automatic" : "R6 random short", exp_code);
        xfer_n = 1'b1;
        tick(SETTLE);
      end else begin
        send_frame(s, len);
        tick(SETTLE);
        check("R8 random hold before strobe", exp_code);
        pulse_xfer();
        if (len >= 16) exp_code = word_code(s);
        check(len >= 16 ? "R4 random manual" : "R6 random short", exp_code);
      end
    end

    // R1: reset after a nonzero code.
    if (exp_code == 12'h000) begin
      send_frame({16'h0001, 8'h00}, 16);
      pulse_xfer();
    end
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    exp_code = 12'h000;
    tick(1);
    check("R1 reset clears code", exp_code);
    pulse_xfer();
    check("R1 R9 no pending word after reset", exp_code);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule